// File: doc/BRIEF.md
# Guest Register Read Accelerator

This block decides, for each guest read of the processor status word or of a CPUID register, whether the read can be satisfied in hardware, whether it must fault, or whether it has to go to the hypervisor. A request carries the kind of read, the guest's virtual-mode flag, the destination register number, the size of the current stacked-register frame, the CPUID index and the live physical values. One cycle later the block returns a result word, a two-bit outcome code and a register-write enable.

The block keeps a virtual status word, a small bank of virtual CPUID entries and three control bits. The monitor loads all of them through a single write port. An accelerated status read returns the stored virtual word. The exceptions are five bits that are never virtualized (bits 5:1, the memory-fault-low, memory-fault-high, alignment-check, user-performance and big-endian flags), which are taken from the physical status word. One combination of control bits is illegal. A control write that requests it is refused and reported.

Top module: `guest_read_accel`

## Requirements
- R1: With the virtual-mode flag clear, a status read returns phys_psr and a CPUID read returns phys_cpuid, with outcome 0. This holds whatever the control bits and the destination are.
- R2: In virtual mode, a status read with control bit 0 clear, or a CPUID read with control bit 1 clear, gives outcome 3 (intercept). This has the highest priority, so a read to destination 0 also gives outcome 3.
- R3: An accelerated status read with no fault returns the virtual status word in every bit except bits 5:1, which come from phys_psr.
- R4: An accelerated read, of either kind, whose destination is register 0 gives outcome 1 (illegal).
- R5: An accelerated read whose destination d is 32 or more gives outcome 1 when d-32 is not less than the frame size. Destinations 1 to 31, and stacked destinations inside the frame, are accepted.
- R6: An accelerated status read gives outcome 2 (privileged) when bits 33:32 of the virtual status word are nonzero. Outcome 1 takes priority over it.
- R7: An accelerated CPUID read with an index below the bank depth (5) returns the entry last written at that index. An index at or above the depth gives outcome 1.
- R8: A control write (mon_sel 2) with bits 0 and 2 both set is refused: the control bits keep their old values and cfg_err is 1 until the next control write. An accepted control write clears cfg_err.
- R9: A virtual status word write (mon_sel 0) is seen by an accelerated read presented in the same cycle and by every later one.
- R10: rsp_valid is high exactly one cycle after req_valid. rsp_wr_en is high only with outcome 0, and rsp_data is zero for any other outcome.
- R11: After reset the control bits, the virtual status word and the CPUID entries are zero, and rsp_valid and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_we | input | 1 | Monitor write strobe |
| mon_sel | input | 2 | Write target: 0 status word, 1 CPUID entry, 2 control, 3 none |
| mon_idx | input | 8 | CPUID entry index for mon_sel 1 |
| mon_wdata | input | 64 | Write data; control bits: 0 status accel, 1 CPUID accel, 2 interrupt-bit virtualization off |
| req_valid | input | 1 | Read request present |
| req_kind | input | 1 | 0 status word read, 1 CPUID read |
| req_vm | input | 1 | Guest virtual-mode flag |
| req_dst | input | 7 | Destination general register |
| req_sof | input | 7 | Current stacked frame size |
| req_cpuid_idx | input | 8 | CPUID index for a CPUID read |
| phys_psr | input | 64 | Live physical status word |
| phys_cpuid | input | 64 | Physical CPUID value for the index |
| rsp_valid | output | 1 | Result present |
| rsp_outcome | output | 2 | 0 ok, 1 illegal, 2 privileged, 3 intercept |
| rsp_data | output | 64 | Result word |
| rsp_wr_en | output | 1 | Destination write enable |
| cfg_err | output | 1 | Last control write was refused |

## Verification
The bench targets the priority edges. It sends reads to register 0 while acceleration is off, which must intercept and not fault. It sends reads with a privileged virtual level to register 0, which must be illegal and not privileged. It probes the frame boundary at d-32 equal to the frame size and one below it, where an off-by-one design would accept an out-of-frame register or reject the top frame register. It writes the virtual word in the same cycle as a read, where a design without forwarding would return the stale word. It also sends a refused control write and then an accelerated read, which exposes a design that applies the forbidden setting, and a CPUID index equal to the depth, which exposes a design that reads past the bank.

// File: rtl/gra_pkg.sv
package gra_pkg;
   typedef enum logic [1:0] {
      OUT_OK        = 2'd0,
      OUT_ILLEGAL   = 2'd1,
      OUT_PRIV      = 2'd2,
      OUT_INTERCEPT = 2'd3
   } outcome_e;

   typedef enum logic [1:0] {
      SEL_VSW   = 2'd0,
      SEL_CPUID = 2'd1,
      SEL_CTL   = 2'd2,
      SEL_NONE  = 2'd3
   } mon_sel_e;

   localparam int CTL_PSR_BIT   = 0;
   localparam int CTL_CPUID_BIT = 1;
   localparam int CTL_IDIS_BIT  = 2;
   localparam int KIND_PSR      = 0;
   localparam int KIND_CPUID    = 1;
endpackage

// File: rtl/gra_ctl_regs.sv
module gra_ctl_regs
   import gra_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter bit VSW_BYPASS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mon_we,
   input  logic [1:0]      mon_sel,
   input  logic [XLEN-1:0] mon_wdata,
   output logic [XLEN-1:0] vsw_eff,
   output logic            en_psr,
   output logic            en_cpuid,
   output logic            en_idis,
   output logic            cfg_err
);
   logic [XLEN-1:0] vsw_q;
   logic            wr_vsw;
   logic            wr_ctl;
   logic            ctl_bad;

   assign wr_vsw  = mon_we && (mon_sel == SEL_VSW);
   assign wr_ctl  = mon_we && (mon_sel == SEL_CTL);
   assign ctl_bad = mon_wdata[CTL_PSR_BIT] && mon_wdata[CTL_IDIS_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsw_q <= '0;
      end else if (wr_vsw) begin
         vsw_q <= mon_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_psr   <= 1'b0;
         en_cpuid <= 1'b0;
         en_idis  <= 1'b0;
         cfg_err  <= 1'b0;
      end else if (wr_ctl) begin
         if (ctl_bad) begin
            cfg_err <= 1'b1;
         end else begin
            en_psr   <= mon_wdata[CTL_PSR_BIT];
            en_cpuid <= mon_wdata[CTL_CPUID_BIT];
            en_idis  <= mon_wdata[CTL_IDIS_BIT];
            cfg_err  <= 1'b0;
         end
      end
   end

   generate
      if (VSW_BYPASS) begin : g_bypass
         assign vsw_eff = wr_vsw ? mon_wdata : vsw_q;
      end else begin : g_direct
         assign vsw_eff = vsw_q;
      end
   endgenerate
endmodule

// File: rtl/gra_cpuid_bank.sv
module gra_cpuid_bank #(
   parameter int XLEN  = 64,
   parameter int DEPTH = 5,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [XLEN-1:0]  rd_data,
   output logic             rd_idx_ok
);
   localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);

   logic [XLEN-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [XLEN-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            val_q <= wr_data;
         end
      end
      assign ent[i] = val_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = ent[i];
         end
      end
   end

   assign rd_idx_ok = ({1'b0, rd_idx} < DEPTH_X);
endmodule

// File: rtl/gra_frame_chk.sv
module gra_frame_chk #(
   parameter int GR_W       = 7,
   parameter int STACK_BASE = 32
) (
   input  logic [GR_W-1:0] dst,
   input  logic [GR_W-1:0] sof,
   output logic            dst_bad
);
   localparam logic [GR_W-1:0] BASE = GR_W'(STACK_BASE);

   logic            is_zero;
   logic            is_stacked;
   logic [GR_W-1:0] slot;

   assign is_zero    = (dst == '0);
   assign is_stacked = (dst >= BASE);
   assign slot       = dst - BASE;
   assign dst_bad    = is_zero || (is_stacked && (slot >= sof));
endmodule

// File: rtl/gra_decide.sv
module gra_decide
   import gra_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter int              CPL_LSB   = 32,
   parameter logic [XLEN-1:0] PHYS_MASK = 'h3E
) (
   input  logic            kind,
   input  logic            vm,
   input  logic            en_psr,
   input  logic            en_cpuid,
   input  logic            dst_bad,
   input  logic            idx_ok,
   input  logic [XLEN-1:0] vsw,
   input  logic [XLEN-1:0] phys_psr,
   input  logic [XLEN-1:0] phys_cpuid,
   input  logic [XLEN-1:0] vcpuid,
   output logic [1:0]      outcome,
   output logic [XLEN-1:0] data
);
   logic [XLEN-1:0] merged;
   logic            cpl_nz;

   assign merged = (vsw & ~PHYS_MASK) | (phys_psr & PHYS_MASK);
   assign cpl_nz = (vsw[CPL_LSB+1 -: 2] != 2'b00);

   always_comb begin
      outcome = OUT_OK;
      data    = '0;
      if (!vm) begin
         data = (kind == 1'(KIND_CPUID)) ? phys_cpuid : phys_psr;
      end else if (kind == 1'(KIND_PSR)) begin
         if (!en_psr)      outcome = OUT_INTERCEPT;
         else if (dst_bad) outcome = OUT_ILLEGAL;
         else if (cpl_nz)  outcome = OUT_PRIV;
         else              data    = merged;
      end else begin
         if (!en_cpuid)               outcome = OUT_INTERCEPT;
         else if (dst_bad || !idx_ok) outcome = OUT_ILLEGAL;
         else                         data    = vcpuid;
      end
   end
endmodule

// File: rtl/guest_read_accel.sv
module guest_read_accel
   import gra_pkg::*;
#(
   parameter int              XLEN        = 64,
   parameter int              CPUID_DEPTH = 5,
   parameter int              CPUID_IDX_W = 8,
   parameter int              GR_W        = 7,
   parameter int              STACK_BASE  = 32,
   parameter int              CPL_LSB     = 32,
   parameter logic [XLEN-1:0] PHYS_MASK   = 'h3E,
   parameter bit              VSW_BYPASS  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mon_we,
   input  logic [1:0]             mon_sel,
   input  logic [CPUID_IDX_W-1:0] mon_idx,
   input  logic [XLEN-1:0]        mon_wdata,
   input  logic                   req_valid,
   input  logic                   req_kind,
   input  logic                   req_vm,
   input  logic [GR_W-1:0]        req_dst,
   input  logic [GR_W-1:0]        req_sof,
   input  logic [CPUID_IDX_W-1:0] req_cpuid_idx,
   input  logic [XLEN-1:0]        phys_psr,
   input  logic [XLEN-1:0]        phys_cpuid,
   output logic                   rsp_valid,
   output logic [1:0]             rsp_outcome,
   output logic [XLEN-1:0]        rsp_data,
   output logic                   rsp_wr_en,
   output logic                   cfg_err
);
   if (CPUID_DEPTH < 1 || CPUID_DEPTH > (1 << CPUID_IDX_W)) begin : g_bad_depth
      $error("CPUID_DEPTH must fit the index width");
   end
   if (CPL_LSB < 0 || CPL_LSB + 1 >= XLEN) begin : g_bad_cpl
      $error("privilege field must lie inside the word");
   end
   if (STACK_BASE < 1 || STACK_BASE >= (1 << GR_W)) begin : g_bad_base
      $error("stacked base must be a valid register number");
   end

   logic [XLEN-1:0] vsw_eff;
   logic            en_psr;
   logic            en_cpuid;
   logic            en_idis;
   logic [XLEN-1:0] vcpuid;
   logic            idx_ok;
   logic            dst_bad;
   logic [1:0]      nxt_outcome;
   logic [XLEN-1:0] nxt_data;

   gra_ctl_regs #(
      .XLEN       (XLEN),
      .VSW_BYPASS (VSW_BYPASS)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon_we    (mon_we),
      .mon_sel   (mon_sel),
      .mon_wdata (mon_wdata),
      .vsw_eff   (vsw_eff),
      .en_psr    (en_psr),
      .en_cpuid  (en_cpuid),
      .en_idis   (en_idis),
      .cfg_err   (cfg_err)
   );

   gra_cpuid_bank #(
      .XLEN  (XLEN),
      .DEPTH (CPUID_DEPTH),
      .IDX_W (CPUID_IDX_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (mon_we && (mon_sel == SEL_CPUID)),
      .wr_idx    (mon_idx),
      .wr_data   (mon_wdata),
      .rd_idx    (req_cpuid_idx),
      .rd_data   (vcpuid),
      .rd_idx_ok (idx_ok)
   );

   gra_frame_chk #(
      .GR_W       (GR_W),
      .STACK_BASE (STACK_BASE)
   ) u_frame (
      .dst     (req_dst),
      .sof     (req_sof),
      .dst_bad (dst_bad)
   );

   gra_decide #(
      .XLEN      (XLEN),
      .CPL_LSB   (CPL_LSB),
      .PHYS_MASK (PHYS_MASK)
   ) u_decide (
      .kind       (req_kind),
      .vm         (req_vm),
      .en_psr     (en_psr),
      .en_cpuid   (en_cpuid),
      .dst_bad    (dst_bad),
      .idx_ok     (idx_ok),
      .vsw        (vsw_eff),
      .phys_psr   (phys_psr),
      .phys_cpuid (phys_cpuid),
      .vcpuid     (vcpuid),
      .outcome    (nxt_outcome),
      .data       (nxt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_outcome <= OUT_OK;
         rsp_data    <= '0;
         rsp_wr_en   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_outcome <= nxt_outcome;
            rsp_data    <= nxt_data;
            rsp_wr_en   <= (nxt_outcome == OUT_OK);
         end else begin
            rsp_wr_en   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/gra_checker.sv
module gra_checker #(
   parameter int XLEN = 64,
   parameter int GR_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_kind,
   input logic            req_vm,
   input logic [GR_W-1:0] req_dst,
   input logic [XLEN-1:0] phys_psr,
   input logic            mon_we,
   input logic [1:0]      mon_sel,
   input logic [XLEN-1:0] mon_wdata,
   input logic            en_psr,
   input logic            en_cpuid,
   input logic            cfg_err,
   input logic            rsp_valid,
   input logic [1:0]      rsp_outcome,
   input logic [XLEN-1:0] rsp_data,
   input logic            rsp_wr_en
);
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outcome != 2'd0) |-> (!rsp_wr_en && rsp_data == '0));

   a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_vm && !req_kind) |=>
         (rsp_outcome == 2'd0 && rsp_data == $past(phys_psr)));

   a_r2_intercept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_vm && ((!req_kind && !en_psr) || (req_kind && !en_cpuid)))
         |=> rsp_outcome == 2'd3);

   a_r4_gr0_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_vm && req_dst == '0 && ((!req_kind && en_psr) || (req_kind && en_cpuid)))
         |=> rsp_outcome == 2'd1);

   a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_we && mon_sel == 2'd2 && mon_wdata[0] && mon_wdata[2])
         |=> (cfg_err && $stable(en_psr) && $stable(en_cpuid)));
endmodule

bind guest_read_accel gra_checker #(
   .XLEN (XLEN),
   .GR_W (GR_W)
) u_gra_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_kind    (req_kind),
   .req_vm      (req_vm),
   .req_dst     (req_dst),
   .phys_psr    (phys_psr),
   .mon_we      (mon_we),
   .mon_sel     (mon_sel),
   .mon_wdata   (mon_wdata),
   .en_psr      (en_psr),
   .en_cpuid    (en_cpuid),
   .cfg_err     (cfg_err),
   .rsp_valid   (rsp_valid),
   .rsp_outcome (rsp_outcome),
   .rsp_data    (rsp_data),
   .rsp_wr_en   (rsp_wr_en)
);

// File: tb/test_guest_read_accel.sv
module test_guest_read_accel;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 5;
   localparam logic [63:0] PMASK = 64'h3E;

   typedef struct {
      logic [1:0]  oc;
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_we = 1'b0;
   logic [1:0]  mon_sel = 2'd3;
   logic [7:0]  mon_idx = '0;
   logic [63:0] mon_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_kind = 1'b0;
   logic        req_vm = 1'b0;
   logic [6:0]  req_dst = '0;
   logic [6:0]  req_sof = '0;
   logic [7:0]  req_cpuid_idx = '0;
   logic [63:0] phys_psr = '0;
   logic [63:0] phys_cpuid = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_outcome;
   logic [63:0] rsp_data;
   logic        rsp_wr_en;
   logic        cfg_err;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   logic [63:0] sh_vsw = '0;
   logic [63:0] sh_cpuid [DEPTH];
   logic        sh_psr = 1'b0, sh_cpu = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   guest_read_accel i_guest_read_accel (
      .clk(clk), .rst_n(rst_n), .mon_we(mon_we), .mon_sel(mon_sel), .mon_idx(mon_idx),
      .mon_wdata(mon_wdata), .req_valid(req_valid), .req_kind(req_kind), .req_vm(req_vm),
      .req_dst(req_dst), .req_sof(req_sof), .req_cpuid_idx(req_cpuid_idx),
      .phys_psr(phys_psr), .phys_cpuid(phys_cpuid), .rsp_valid(rsp_valid),
      .rsp_outcome(rsp_outcome), .rsp_data(rsp_data), .rsp_wr_en(rsp_wr_en), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit dst_bad(input logic [6:0] d, input logic [6:0] s);
      return (d == 0) || (d >= 32 && (d - 7'd32) >= s);
   endfunction

   function automatic exp_t model(input logic k, input logic vm, input logic [6:0] d,
                                  input logic [6:0] s, input logic [7:0] idx,
                                  input logic [63:0] pp, input logic [63:0] pc, input string tag);
      exp_t e;
      e.oc = 2'd0; e.data = '0; e.tag = tag;
      if (!vm) e.data = k ? pc : pp;
      else if (!k) begin
         if (!sh_psr)                 e.oc = 2'd3;
         else if (dst_bad(d, s))      e.oc = 2'd1;
         else if (sh_vsw[33:32] != 0) e.oc = 2'd2;
         else e.data = (sh_vsw & ~PMASK) | (pp & PMASK);
      end else begin
         if (!sh_cpu)                             e.oc = 2'd3;
         else if (dst_bad(d, s) || idx >= DEPTH)  e.oc = 2'd1;
         else e.data = sh_cpuid[idx];
      end
      return e;
   endfunction

   // one cycle: optional monitor write plus optional request
   task automatic step(input bit wr, input logic [1:0] sel, input logic [7:0] widx,
                       input logic [63:0] wd, input bit rd, input logic k, input logic vm,
                       input logic [6:0] d, input logic [6:0] s, input logic [7:0] idx,
                       input logic [63:0] pp, input logic [63:0] pc, input string tag);
      mon_we = wr; mon_sel = sel; mon_idx = widx; mon_wdata = wd;
      req_valid = rd; req_kind = k; req_vm = vm; req_dst = d; req_sof = s;
      req_cpuid_idx = idx; phys_psr = pp; phys_cpuid = pc;
      if (wr && sel == 2'd0) sh_vsw = wd;            // same-cycle forwarding (R9)
      if (rd) q.push_back(model(k, vm, d, s, idx, pp, pc, tag));
      if (wr && sel == 2'd1 && widx < DEPTH) sh_cpuid[widx] = wd;
      if (wr && sel == 2'd2 && !(wd[0] && wd[2])) begin
         sh_psr = wd[0]; sh_cpu = wd[1];
      end
      @(negedge clk);
      mon_we = 1'b0; mon_sel = 2'd3; req_valid = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] widx, input logic [63:0] wd);
      step(1'b1, sel, widx, wd, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, "");
   endtask

   task automatic rd(input logic k, input logic vm, input logic [6:0] d, input logic [6:0] s,
                     input logic [7:0] idx, input logic [63:0] pp, input logic [63:0] pc,
                     input string tag);
      step(1'b0, 2'd3, '0, '0, 1'b1, k, vm, d, s, idx, pp, pc, tag);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rsp_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R10 unexpected response", {63'd0, rsp_valid}, 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(rsp_outcome == e.oc, {e.tag, " outcome"}, {62'd0, rsp_outcome}, {62'd0, e.oc});
               check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
               check(rsp_wr_en == (e.oc == 2'd0), "R10 write enable", {63'd0, rsp_wr_en},
                     {63'd0, e.oc == 2'd0});
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] pa, pb;
      pa = 64'hFFFF_FFFF_FFFF_FFFF;
      pb = 64'h0123_4567_89AB_CDEF;
      for (int i = 0; i < DEPTH; i++) sh_cpuid[i] = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(rsp_valid == 1'b0, "R11 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
      check(cfg_err == 1'b0, "R11 cfg_err after reset", {63'd0, cfg_err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 pass-through, R2 intercept (including destination 0)
      rd(1'b0, 1'b0, 7'd0, 7'd0, 8'd0, pb, pa, "R1 psr passthrough");
      rd(1'b1, 1'b0, 7'd0, 7'd0, 8'd9, pb, pa, "R1 cpuid passthrough");
      rd(1'b0, 1'b1, 7'd5, 7'd0, 8'd0, pb, pa, "R2 psr intercept");
      rd(1'b0, 1'b1, 7'd0, 7'd0, 8'd0, pb, pa, "R2 intercept over gr0");
      rd(1'b1, 1'b1, 7'd0, 7'd0, 8'd0, pb, pa, "R2 cpuid intercept");

      // R11 virtual word and CPUID entries start at zero
      wr(2'd2, '0, 64'h3);
      check(cfg_err == 1'b0, "R8 accepted control", {63'd0, cfg_err}, 64'd0);
      rd(1'b0, 1'b1, 7'd4, 7'd0, 8'd0, pa, '0, "R11 zero virtual word");
      rd(1'b1, 1'b1, 7'd4, 7'd0, 8'd2, pa, '0, "R11 zero cpuid entry");

      // R3 merge, R4 gr0, R5 frame
      wr(2'd0, '0, 64'h1234_5670_A5A5_5A40);
      rd(1'b0, 1'b1, 7'd8, 7'd0, 8'd0, pa, '0, "R3 merge ones");
      rd(1'b0, 1'b1, 7'd8, 7'd0, 8'd0, 64'h0, '0, "R3 merge zeros");
      rd(1'b0, 1'b1, 7'd0, 7'd10, 8'd0, pa, '0, "R4 psr gr0");
      rd(1'b0, 1'b1, 7'd32, 7'd0, 8'd0, pa, '0, "R5 empty frame");
      rd(1'b0, 1'b1, 7'd40, 7'd8, 8'd0, pa, '0, "R5 at frame end");
      rd(1'b0, 1'b1, 7'd39, 7'd8, 8'd0, pa, '0, "R5 top of frame");
      rd(1'b0, 1'b1, 7'd31, 7'd0, 8'd0, pa, '0, "R5 static register");
      rd(1'b0, 1'b1, 7'd127, 7'd96, 8'd0, pa, '0, "R5 full frame");

      // R6 privileged and its priority
      wr(2'd0, '0, 64'h0000_0003_0000_1000);
      rd(1'b0, 1'b1, 7'd9, 7'd0, 8'd0, pb, '0, "R6 privileged");
      rd(1'b0, 1'b1, 7'd0, 7'd0, 8'd0, pb, '0, "R6 illegal before privileged");
      wr(2'd0, '0, 64'h0000_0001_0000_0000);
      rd(1'b0, 1'b1, 7'd33, 7'd2, 8'd0, pb, '0, "R6 low privilege bit");

      // R9 same-cycle write then read
      step(1'b1, 2'd0, '0, 64'hCAFE_0000_F00D_0000, 1'b1, 1'b0, 1'b1, 7'd3, 7'd0, 8'd0,
           pb, '0, "R9 same cycle");
      rd(1'b0, 1'b1, 7'd3, 7'd0, 8'd0, pa, '0, "R9 later read");

      // R7 CPUID bank
      for (int i = 0; i < DEPTH; i++) wr(2'd1, 8'(i), 64'h1111_0000_0000_0000 * (i + 1) + 64'(i));
      for (int i = 0; i < DEPTH; i++) rd(1'b1, 1'b1, 7'd12, 7'd0, 8'(i), pa, pb, "R7 entry");
      rd(1'b1, 1'b1, 7'd12, 7'd0, 8'd5, pa, pb, "R7 index at depth");
      rd(1'b1, 1'b1, 7'd12, 7'd0, 8'd255, pa, pb, "R7 index max");
      rd(1'b1, 1'b1, 7'd0, 7'd0, 8'd1, pa, pb, "R4 cpuid gr0");
      rd(1'b1, 1'b1, 7'd50, 7'd4, 8'd1, pa, pb, "R5 cpuid out of frame");

      // R8 refused control write
      wr(2'd0, '0, 64'h0000_0000_0000_0F00);
      wr(2'd2, '0, 64'h5);
      check(cfg_err == 1'b1, "R8 refused control", {63'd0, cfg_err}, 64'd1);
      rd(1'b0, 1'b1, 7'd6, 7'd0, 8'd0, pb, '0, "R8 status enable kept");
      rd(1'b1, 1'b1, 7'd6, 7'd0, 8'd0, pb, pa, "R8 cpuid enable kept");
      check(cfg_err == 1'b1, "R8 cfg_err held", {63'd0, cfg_err}, 64'd1);
      wr(2'd2, '0, 64'h4);
      check(cfg_err == 1'b0, "R8 cleared by accepted write", {63'd0, cfg_err}, 64'd0);
      rd(1'b0, 1'b1, 7'd6, 7'd0, 8'd0, pb, '0, "R8 new control applied");

      // R10 idle gap
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10 idle gap", {63'd0, rsp_valid}, 64'd0);
      repeat (2) @(negedge clk);
      check(q.size() == 0, "R10 responses drained", 64'(q.size()), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule